// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Mask Comparison

This block gathers interrupt requests from a set of external interrupt pins and from on-chip peripheral request lines, gives each source a 4-bit priority level held in software-programmable registers, and presents one winning request to the processor. Every cycle a combinational arbiter finds the requesting source with the largest level, breaking ties by a fixed source order. The winner is compared against the processor's current 4-bit mask, and only a strictly larger level is forwarded. The forwarded request (valid, level, vector number) and an active-low interrupt-out pin are registered, so they follow the sampled inputs by one clock.

External pins can be sensed by level or by a falling edge. An edge is latched into a pending flag that stays set until the processor acknowledges that source or software cancels it through the register bus. When the processor acknowledges, the interrupt-out pin is released for a level-type or peripheral source. For an edge-type source it stays low only if a strictly higher-level request is accepted at that moment.

Top module: `prio_intc`

## Requirements
- R1: After reset, cpu_req is 0, cpu_lvl and cpu_vec are 0, irq_out_n is 1, and every register reads back 0 (all levels 0, all pins level-sensed, no pending flags).
- R2: Among the requesting sources the one with the largest programmed level wins, whatever its source index.
- R3: When several requesting sources share the winning level, the one with the lowest source index wins. External pin k is source k (0 to N_IRQ-1) and peripheral line j is source N_IRQ+j.
- R4: A winner is forwarded only if its level is strictly greater than cpu_mask; an equal or lower level gives cpu_req 0.
- R5: A source whose level is 0 never produces a request.
- R6: The outputs are registered. Inputs sampled at one rising edge show at the outputs after that edge. While cpu_req is 1, cpu_vec equals VEC_BASE (default 64) plus the winner's source index and irq_out_n is 0. While cpu_req is 0, cpu_lvl and cpu_vec are 0 and irq_out_n is 1.
- R7: If cpu_ack is sampled high while a level-sensed pin or a peripheral source is presented, cpu_req drops to 0 and irq_out_n goes high after that edge.
- R8: If cpu_ack is sampled high while an edge-sensed pin is presented, the pin's pending flag clears. The request is then replaced by the best other source only if that source's level is strictly above the acknowledged level and above cpu_mask, and irq_out_n stays low. Otherwise cpu_req drops to 0.
- R9: In edge mode, a high-to-low transition on an external pin sets its pending flag. The flag keeps the request alive after the pin returns high, including while the mask blocks it. The request appears at the outputs one edge after the flag is set.
- R10: Writing 1 to bit k of the pending register (address 11) cancels the pending edge flag of pin k, and no request follows from it.
- R11: Register bus: addresses 0 to 9 are 16-bit level registers, and source s uses bits [4(s%4)+3 : 4(s%4)] of register s/4. Address 10 bit k selects edge sensing for pin k (1 = edge). Address 11 reads the pending flags. Writes take effect at the clock edge where bus_wr is sampled, and bus_rdata follows bus_addr combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_n | input | N_IRQ | External interrupt pins, active low |
| per_req | input | N_PER | Peripheral request lines, active high |
| cpu_mask | input | 4 | Processor's current mask level |
| cpu_ack | input | 1 | Processor begins servicing the presented request |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_wdata | input | 16 | Register write data |
| bus_rdata | output | 16 | Register read data |
| cpu_req | output | 1 | Request to the processor |
| cpu_lvl | output | 4 | Level of the presented request |
| cpu_vec | output | 8 | Vector number of the presented request |
| irq_out_n | output | 1 | Active-low interrupt-out pin |

## Verification
The assertions assume that all inputs are synchronous to clk and that cpu_ack is raised only while cpu_req is high and lasts a single cycle. They also assume that a processor which takes a level-type request lifts cpu_mask before the next comparison. The stimulus changes every input only on falling clock edges and pulses cpu_ack for exactly one cycle over a presented request. After acknowledging a level-type source, it raises cpu_mask to the taken level or removes the request.

// File: rtl/pintc_pkg.sv
package pintc_pkg;

  localparam int LVL_W         = 4;
  localparam int VEC_W         = 8;
  localparam int BUS_AW        = 4;
  localparam int BUS_DW        = 16;
  localparam int NUM_PRIO_REGS = 10;
  localparam int FIELDS_PER_REG = BUS_DW / LVL_W;

  localparam logic [BUS_AW-1:0] ADDR_PRIO_END = BUS_AW'(NUM_PRIO_REGS);
  localparam logic [BUS_AW-1:0] ADDR_SENSE    = 4'd10;
  localparam logic [BUS_AW-1:0] ADDR_PEND     = 4'd11;

  typedef logic [LVL_W-1:0] lvl_t;

  // candidate replaces the current best only when strictly larger,
  // so an earlier (lower index) source keeps a tie
  function automatic logic lvl_beats(input lvl_t cand, input lvl_t best);
    return cand > best;
  endfunction

  // the processor takes a request only above its mask
  function automatic logic lvl_accepted(input lvl_t lvl, input lvl_t mask);
    return lvl > mask;
  endfunction

endpackage

// File: rtl/pintc_regfile.sv
module pintc_regfile
  import pintc_pkg::*;
#(
  parameter int N_IRQ = 8,
  parameter int N_SRC = 20
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [BUS_AW-1:0]             bus_addr,
  input  logic                          bus_wr,
  input  logic [BUS_DW-1:0]             bus_wdata,
  input  logic [N_IRQ-1:0]              pend,
  output logic [BUS_DW-1:0]             bus_rdata,
  output logic [N_SRC-1:0][LVL_W-1:0]   src_lvl,
  output logic [N_IRQ-1:0]              edge_mode,
  output logic [N_IRQ-1:0]              cancel
);

  logic [NUM_PRIO_REGS-1:0][BUS_DW-1:0] prio_q;
  logic [N_IRQ-1:0]                     mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      mode_q <= '0;
    end else if (bus_wr) begin
      if (bus_addr < ADDR_PRIO_END) prio_q[bus_addr] <= bus_wdata;
      if (bus_addr == ADDR_SENSE)   mode_q <= bus_wdata[N_IRQ-1:0];
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_field
    assign src_lvl[s] = prio_q[s / FIELDS_PER_REG][(s % FIELDS_PER_REG)*LVL_W +: LVL_W];
  end

  assign edge_mode = mode_q;
  assign cancel    = (bus_wr && bus_addr == ADDR_PEND) ? bus_wdata[N_IRQ-1:0] : '0;

  always_comb begin
    bus_rdata = '0;
    if (bus_addr < ADDR_PRIO_END)   bus_rdata = prio_q[bus_addr];
    else if (bus_addr == ADDR_SENSE) bus_rdata[N_IRQ-1:0] = mode_q;
    else if (bus_addr == ADDR_PEND)  bus_rdata[N_IRQ-1:0] = pend;
  end

endmodule

// File: rtl/pintc_irq_sense.sv
module pintc_irq_sense
  import pintc_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] irq_n,
  input  logic [N_IRQ-1:0] edge_mode,
  input  logic [N_IRQ-1:0] cancel,
  input  logic [N_IRQ-1:0] ack_clr,
  output logic [N_IRQ-1:0] irq_req,
  output logic [N_IRQ-1:0] pend
);

  logic [N_IRQ-1:0] prev_q;
  logic [N_IRQ-1:0] pend_q;
  logic [N_IRQ-1:0] fall;
  logic [N_IRQ-1:0] drop;

  assign fall = prev_q & ~irq_n & edge_mode;
  assign drop = cancel | ack_clr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '1;
      pend_q <= '0;
    end else begin
      prev_q <= irq_n;
      pend_q <= (pend_q & ~drop) | fall;   // a fresh edge wins over a clear
    end
  end

  assign irq_req = (edge_mode & pend_q) | (~edge_mode & ~irq_n);
  assign pend    = pend_q;

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack_clr & ~fall)) |=> ((pend_q & $past(ack_clr & ~fall)) == '0));

  assert_cancel_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cancel & ~fall)) |=> ((pend_q & $past(cancel & ~fall)) == '0));

  assert_pending_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pend_q & ~drop)) |=> ((pend_q & $past(pend_q & ~drop)) == $past(pend_q & ~drop)));

endmodule

// File: rtl/pintc_arbiter.sv
module pintc_arbiter
  import pintc_pkg::*;
#(
  parameter int N_SRC = 20,
  parameter int SRC_W = 5
) (
  input  logic [N_SRC-1:0]            req,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl,
  output logic                        win_valid,
  output lvl_t                        win_lvl,
  output logic [SRC_W-1:0]            win_src
);

  always_comb begin
    win_lvl = '0;
    win_src = '0;
    for (int s = 0; s < N_SRC; s++) begin
      if (req[s] && lvl_beats(lvl[s], win_lvl)) begin
        win_lvl = lvl[s];
        win_src = SRC_W'(s);
      end
    end
    win_valid = (win_lvl != '0);
  end

endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import pintc_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int N_PER    = 12,
  parameter int VEC_BASE = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_n,
  input  logic [N_PER-1:0]  per_req,
  input  logic [LVL_W-1:0]  cpu_mask,
  input  logic              cpu_ack,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              cpu_req,
  output logic [LVL_W-1:0]  cpu_lvl,
  output logic [VEC_W-1:0]  cpu_vec,
  output logic              irq_out_n
);

  localparam int N_SRC = N_IRQ + N_PER;
  localparam int SRC_W = $clog2(N_SRC);

  logic [N_SRC-1:0][LVL_W-1:0] src_lvl;
  logic [N_IRQ-1:0]            edge_mode, cancel, ack_clr, irq_req, pend;
  logic [N_SRC-1:0]            req_all, edge_src, ack_onehot;

  logic                        win_valid_a, win_valid_b;
  lvl_t                        win_lvl_a, win_lvl_b;
  logic [SRC_W-1:0]            win_src_a, win_src_b;

  logic                        req_q;
  lvl_t                        lvl_q;
  logic [SRC_W-1:0]            src_q;

  // named events used by the register stage and the assertions
  logic ack_take, src_is_edge, accept_main, accept_hold;

  pintc_regfile #(.N_IRQ(N_IRQ), .N_SRC(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pend(pend), .bus_rdata(bus_rdata),
    .src_lvl(src_lvl), .edge_mode(edge_mode), .cancel(cancel)
  );

  pintc_irq_sense #(.N_IRQ(N_IRQ)) u_sense (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .edge_mode(edge_mode),
    .cancel(cancel), .ack_clr(ack_clr), .irq_req(irq_req), .pend(pend)
  );

  assign req_all  = {per_req, irq_req};
  assign edge_src = {{N_PER{1'b0}}, edge_mode};

  assign ack_take    = cpu_ack && req_q;
  assign src_is_edge = edge_src[src_q];
  assign ack_onehot  = ack_take ? (N_SRC'(1) << src_q) : '0;
  assign ack_clr     = src_is_edge ? ack_onehot[N_IRQ-1:0] : '0;

  // main arbitration over every live request
  pintc_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb_main (
    .req(req_all), .lvl(src_lvl),
    .win_valid(win_valid_a), .win_lvl(win_lvl_a), .win_src(win_src_a)
  );

  // arbitration with the acknowledged source removed
  pintc_arbiter #(.N_SRC(N_SRC), .SRC_W(SRC_W)) u_arb_other (
    .req(req_all & ~ack_onehot), .lvl(src_lvl),
    .win_valid(win_valid_b), .win_lvl(win_lvl_b), .win_src(win_src_b)
  );

  assign accept_main = win_valid_a && lvl_accepted(win_lvl_a, cpu_mask);
  assign accept_hold = win_valid_b && lvl_beats(win_lvl_b, lvl_q)
                       && lvl_accepted(win_lvl_b, cpu_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      src_q <= '0;
    end else if (ack_take) begin
      if (src_is_edge && accept_hold) begin
        req_q <= 1'b1;
        lvl_q <= win_lvl_b;
        src_q <= win_src_b;
      end else begin
        req_q <= 1'b0;
        lvl_q <= '0;
        src_q <= '0;
      end
    end else begin
      req_q <= accept_main;
      lvl_q <= accept_main ? win_lvl_a : '0;
      src_q <= accept_main ? win_src_a : '0;
    end
  end

  assign cpu_req   = req_q;
  assign cpu_lvl   = lvl_q;
  assign cpu_vec   = req_q ? (VEC_W'(VEC_BASE) + VEC_W'(src_q)) : '0;
  assign irq_out_n = ~req_q;

  assert_accept_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) |-> (cpu_lvl > $past(cpu_mask)));

  assert_zero_level_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_req) |-> (cpu_lvl != '0));

  assert_level_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && !src_is_edge) |=> !cpu_req);

  assert_edge_hold_higher_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_take && src_is_edge) |=> (!cpu_req || (cpu_lvl > $past(lvl_q))));

  for (genvar s = 0; s < N_SRC; s++) begin : g_arb_chk
    assert_winner_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_all[s] |-> (src_lvl[s] <= win_lvl_a));

    assert_tie_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_all[s] && win_valid_a && src_lvl[s] == win_lvl_a) |-> (win_src_a <= SRC_W'(s)));
  end

endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N_IRQ      = 8;
  localparam int N_PER      = 12;
  localparam int N_SRC      = N_IRQ + N_PER;
  localparam int VEC_BASE   = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [N_IRQ-1:0]  irq_n;
  logic [N_PER-1:0]  per_req;
  logic [3:0]        cpu_mask;
  logic              cpu_ack;
  logic [3:0]        bus_addr;
  logic              bus_wr;
  logic [15:0]       bus_wdata;
  logic [15:0]       bus_rdata;
  logic              cpu_req;
  logic [3:0]        cpu_lvl;
  logic [7:0]        cpu_vec;
  logic              irq_out_n;

  prio_intc #(.N_IRQ(N_IRQ), .N_PER(N_PER), .VEC_BASE(VEC_BASE)) u_prio_intc (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .per_req(per_req),
    .cpu_mask(cpu_mask), .cpu_ack(cpu_ack), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cpu_req(cpu_req), .cpu_lvl(cpu_lvl), .cpu_vec(cpu_vec),
    .irq_out_n(irq_out_n)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          is_read;
    logic [15:0] rd;
    logic        req;
    logic [3:0]  lvl;
    logic [7:0]  vec;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  int          checks = 0;
  int          errors = 0;
  bit          done   = 1'b0;
  logic [15:0] shadow [10];

  // ---------------- scoreboard monitor ----------------
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (it.is_read) begin
          if (bus_rdata !== it.rd) begin
            errors++;
            $display("FAIL %s: bus_rdata actual %h expected %h", it.tag, bus_rdata, it.rd);
          end
        end else if (cpu_req !== it.req || cpu_lvl !== it.lvl ||
                     cpu_vec !== it.vec || irq_out_n !== ~it.req) begin
          errors++;
          $display("FAIL %s: actual req=%b lvl=%0d vec=%0d out_n=%b expected req=%b lvl=%0d vec=%0d out_n=%b",
                   it.tag, cpu_req, cpu_lvl, cpu_vec, irq_out_n,
                   it.req, it.lvl, it.vec, ~it.req);
        end
      end
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- driver helpers ----------------
  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic exp_cpu(input logic r, input logic [3:0] l, input int src, input string tag);
    item_t it;
    it.is_read = 1'b0; it.rd = '0; it.req = r;
    it.lvl = r ? l : 4'd0;
    it.vec = r ? 8'(VEC_BASE + src) : 8'd0;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic exp_idle(input string tag);
    exp_cpu(1'b0, 4'd0, 0, tag);
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [15:0] v, input string tag);
    item_t it;
    bus_addr = a;
    it.is_read = 1'b1; it.rd = v; it.req = 1'b0; it.lvl = '0; it.vec = '0; it.tag = tag;
    sb_q.push_back(it);
    cyc();
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    cyc();
    bus_wr = 1'b0;
  endtask

  task automatic set_prio(input int src, input logic [3:0] l);
    shadow[src/4][(src%4)*4 +: 4] = l;
    bus_write(4'(src/4), shadow[src/4]);
  endtask

  function automatic logic [3:0] model_lvl(input int src);
    return shadow[src/4][(src%4)*4 +: 4];
  endfunction

  // bench-side arbitration: scan levels from the top, first index at that level
  task automatic exp_pick(input logic [N_SRC-1:0] reqs, input logic [3:0] mask, input string tag);
    int found = -1;
    logic [3:0] fl = '0;
    for (int l = 15; l > mask && found < 0; l--) begin
      for (int s = 0; s < N_SRC && found < 0; s++) begin
        if (reqs[s] && model_lvl(s) == 4'(l)) begin
          found = s;
          fl = 4'(l);
        end
      end
    end
    if (found < 0) exp_idle(tag);
    else           exp_cpu(1'b1, fl, found, tag);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    for (int i = 0; i < 10; i++) shadow[i] = '0;
    rst_n = 1'b0; irq_n = '1; per_req = '0; cpu_mask = '0; cpu_ack = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1: reset state
    exp_idle("R1 outputs after reset");
    rd_check(4'd0,  16'h0000, "R1 level reg 0");
    rd_check(4'd10, 16'h0000, "R1 sense reg");
    rd_check(4'd11, 16'h0000, "R1 pending reg");

    // program levels: src2=5, src3=5, src9=7, src10=7, src12 left at 0
    set_prio(2, 4'd5);
    set_prio(3, 4'd5);
    set_prio(9, 4'd7);
    set_prio(10, 4'd7);
    rd_check(4'd0, 16'h5500, "R11 level reg 0 readback");
    rd_check(4'd2, 16'h0770, "R11 level reg 2 readback");

    // R6: latency and vector
    per_req = 12'h002;                       // source 9
    exp_idle("R6 no output before the edge");
    cyc();
    exp_cpu(1'b1, 4'd7, 9, "R6 vector of source 9");
    per_req = 12'h006;                       // sources 9 and 10, both level 7
    cyc();
    exp_pick(20'h00600, 4'd0, "R3 tie between peripherals");
    per_req = 12'h004;
    cyc();
    exp_cpu(1'b1, 4'd7, 10, "R3 remaining source 10");

    // R4: strict comparison with the mask
    cpu_mask = 4'd7;
    cyc();
    exp_idle("R4 level equal to mask ignored");
    cpu_mask = 4'd6;
    cyc();
    exp_cpu(1'b1, 4'd7, 10, "R4 level above mask taken");

    // R7: acknowledge of a peripheral request
    cpu_ack = 1'b1;
    cyc();
    exp_idle("R7 pin released after level ack");
    cpu_ack = 1'b0; cpu_mask = 4'd7;
    cyc();
    exp_idle("R7 stays released under raised mask");
    per_req = '0; cpu_mask = 4'd0;
    cyc();

    // R5: zero level never requests
    per_req = 12'h010;                       // source 12, level 0
    cyc();
    exp_idle("R5 level 0 source silent");
    cyc();
    exp_idle("R5 level 0 source still silent");
    per_req = '0;

    // R2: higher level wins regardless of index
    irq_n = ~8'h04; per_req = 12'h002;       // source 2 (5) and source 9 (7)
    cyc();
    exp_pick(20'h00204, 4'd0, "R2 higher level peripheral beats pin");
    per_req = '0;
    cyc();
    exp_cpu(1'b1, 4'd5, 2, "R2 lower level once alone");
    irq_n = ~8'h0C;                          // sources 2 and 3, both level 5
    cyc();
    exp_cpu(1'b1, 4'd5, 2, "R3 tie between pins");
    irq_n = '1;
    cyc();
    exp_idle("R6 idle after release");

    // R9: edge mode on pin 3
    bus_write(4'd10, 16'h0008);
    rd_check(4'd10, 16'h0008, "R11 sense readback");
    irq_n = ~8'h08;
    cyc();
    exp_idle("R9 flag not yet visible");
    irq_n = '1;
    cyc();
    exp_cpu(1'b1, 4'd5, 3, "R9 edge request held after pin returns");
    rd_check(4'd11, 16'h0008, "R11 pending flag readback");

    // R8: edge ack with only an equal-level competitor
    cpu_ack = 1'b1; irq_n = ~8'h04;          // source 2 level-sensed, level 5
    cyc();
    exp_idle("R8 edge ack released with equal competitor");
    cpu_ack = 1'b0;
    bus_addr = 4'd11;
    begin
      item_t it;
      it.is_read = 1'b1; it.rd = 16'h0000; it.req = 1'b0; it.lvl = '0; it.vec = '0;
      it.tag = "R8 pending cleared by ack";
      sb_q.push_back(it);
    end
    cyc();
    exp_cpu(1'b1, 4'd5, 2, "R8 competitor presented afterwards");
    irq_n = '1;
    cyc();
    exp_idle("R8 idle again");

    // R8: edge ack with a higher competitor keeps the pin low
    irq_n = ~8'h08;
    cyc();
    irq_n = '1;
    cyc();
    exp_cpu(1'b1, 4'd5, 3, "R9 second edge presented");
    cpu_ack = 1'b1; per_req = 12'h002;       // source 9, level 7
    cyc();
    exp_cpu(1'b1, 4'd7, 9, "R8 higher request holds pin low");
    cpu_ack = 1'b0;
    rd_check(4'd11, 16'h0000, "R8 pending cleared under hold");
    per_req = '0;
    cyc();
    exp_idle("R8 idle after hold");

    // R10: software cancel of a masked pending edge
    cpu_mask = 4'd15;
    irq_n = ~8'h08;
    cyc();
    irq_n = '1;
    cyc();
    exp_idle("R4 mask 15 blocks pending edge");
    rd_check(4'd11, 16'h0008, "R9 pending held while masked");
    bus_write(4'd11, 16'h0008);
    rd_check(4'd11, 16'h0000, "R10 pending cancelled");
    cpu_mask = 4'd0;
    cyc();
    exp_idle("R10 no request after cancel");
    cyc();
    exp_idle("R10 still no request");

    cyc();
    cyc();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule